// File: doc/BRIEF.md
# Transport Clock Reference Extractor

The block watches a byte-wide MPEG transport stream for packets that carry one PID chosen by the host. When a matching packet holds an adaptation field with a program clock reference, the block captures the 33-bit base and the 9-bit extension into holding outputs. It then raises a one-cycle compare event. A downstream clock-recovery loop uses that event to latch its local time and compare it with the captured value.

A separate load event goes out with the compare event when the local counter should be overwritten rather than steered. This happens after the host has programmed the PID with its enable bit set, or after the stream has shown a discontinuity since the previous reference. A discontinuity is either the flag in the adaptation field or a break in the continuity counter. The pending-load state clears once the load event has gone out. A soft reset clears only the packet-processing state. The programmed PID, the enable bit, the captured value and any pending load all survive it.

Top module: `pcr_extract`

## Requirements
- R1: After the asynchronous reset, `pcr_base_o`, `pcr_ext_o`, `cmp_evt_o` and `load_evt_o` are zero, and no PID is enabled.
- R2: A packet is only considered when its first byte (marked by `pkt_start_i`) equals 0x47 and its 13-bit PID (byte 1 bits 4:0 as PID bits 12:8, byte 2 as bits 7:0) equals the programmed PID with the enable bit set. All 13 bits take part in the match.
- R3: A reference is present when the field-control bits (byte 3 bits 5:4) have bit 5 set, the field length (byte 4) is nonzero, and the flags byte (byte 5) has bit 4 set. Bytes 6 to 11 then form a 48-bit word sent MSB first: base = bits 47:15, extension = bits 8:0, and bits 14:9 are ignored.
- R4: `cmp_evt_o` pulses for exactly one cycle, in the cycle after the last reference byte is accepted. `pcr_base_o` and `pcr_ext_o` change only in that cycle and hold their value otherwise.
- R5: A host write with `pid_wvld_i` high makes the next compare event carry `load_evt_o`. `load_evt_o` never pulses without `cmp_evt_o`.
- R6: A matching packet whose flags byte has bit 7 set (while an adaptation field is present) makes the next compare event carry a load, including a reference in that same packet.
- R7: The continuity counter is byte 3 bits 3:0. It is expected to advance by one (mod 16) on matching packets whose payload bit (byte 3 bit 4) is set, and to stay equal on packets without payload. Any other value marks a discontinuity and requests a load. The first packet after a PID write or soft reset sets the history and never counts as a jump.
- R8: The pending load clears when its load event is issued, so the next reference with no new cause carries no load.
- R9: A host write with `pid_wvld_i` low disables matching, and no further events are produced.
- R10: `soft_rst_i` abandons the packet in progress, so none of its remaining bytes produce events. It also clears the continuity history. The programmed PID, the captured value and any pending load are left as they were.
- R11: Bytes count only while `byte_vld_i` is high, so idle cycles inside a packet do not shift positions. A new `pkt_start_i` restarts parsing at byte 0 even in mid-packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| soft_rst_i | input | 1 | Synchronous clear of the packet-processing state |
| byte_i | input | 8 | Stream byte |
| byte_vld_i | input | 1 | `byte_i` is valid this cycle |
| pkt_start_i | input | 1 | Current valid byte is byte 0 of a packet |
| pid_wr_i | input | 1 | Host write strobe for the PID register |
| pid_wdata_i | input | 13 | PID to search for |
| pid_wvld_i | input | 1 | Enable bit written with the PID |
| pcr_base_o | output | 33 | Captured reference base |
| pcr_ext_o | output | 9 | Captured reference extension |
| cmp_evt_o | output | 1 | One-cycle pulse per captured reference |
| load_evt_o | output | 1 | One-cycle pulse with `cmp_evt_o` when a load is due |

## Verification
The hardest behaviour to reach is the continuity check, because it depends on the history across several packets. A counter break only means something after earlier packets have set the expected value. Packets without payload must hold that value, and a PID write or soft reset must wipe it. The stimulus walks one PID through an ordered run of packets: an in-sequence step, a deliberate jump, an adaptation-only packet that repeats the counter, and a resumed sequence. After that comes a packet abandoned by soft reset and then one with an arbitrary counter. The load bit expected on each reference follows from that history.

// File: rtl/pcr_pkg.sv
package pcr_pkg;
  localparam logic [7:0] SYNC_BYTE = 8'h47;
  localparam int PKT_LEN  = 188;
  localparam int PID_W    = 13;
  localparam int CC_W     = 4;
  localparam int BASE_W   = 33;
  localparam int EXT_W    = 9;
  localparam int RSVD_W   = 6;
  localparam int PCR_BYTES = (BASE_W + RSVD_W + EXT_W) / 8;
  // byte positions inside a packet
  localparam int POS_PID_HI = 1;
  localparam int POS_PID_LO = 2;
  localparam int POS_HDR    = 3;
  localparam int POS_AFLEN  = 4;
  localparam int POS_AFFLG  = 5;
  localparam int POS_PCR0   = 6;
endpackage

// File: rtl/ts_pkt_parser.sv
module ts_pkt_parser
  import pcr_pkg::*;
#(
  parameter int PKT_BYTES = PKT_LEN,
  parameter int PW        = PID_W,
  parameter int NPCR      = PCR_BYTES
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          soft_rst_i,
  input  logic [7:0]    byte_i,
  input  logic          byte_vld_i,
  input  logic          pkt_start_i,
  input  logic [PW-1:0] pid_i,
  input  logic          pid_vld_i,
  output logic          hdr_evt_o,
  output logic [CC_W-1:0] cc_o,
  output logic          payload_o,
  output logic          disc_evt_o,
  output logic          pcr_byte_o,
  output logic          pcr_last_o
);
  localparam int CNT_W = $clog2(PKT_BYTES + 1);
  localparam logic [CNT_W-1:0] I_PID_HI = CNT_W'(POS_PID_HI);
  localparam logic [CNT_W-1:0] I_PID_LO = CNT_W'(POS_PID_LO);
  localparam logic [CNT_W-1:0] I_HDR    = CNT_W'(POS_HDR);
  localparam logic [CNT_W-1:0] I_AFLEN  = CNT_W'(POS_AFLEN);
  localparam logic [CNT_W-1:0] I_AFFLG  = CNT_W'(POS_AFFLG);
  localparam logic [CNT_W-1:0] I_PCR0   = CNT_W'(POS_PCR0);
  localparam logic [CNT_W-1:0] I_PCRN   = CNT_W'(POS_PCR0 + NPCR - 1);
  localparam logic [CNT_W-1:0] I_LAST   = CNT_W'(PKT_BYTES - 1);
  localparam int HI_W = PW - 8;

  logic [CNT_W-1:0] cnt_q;
  logic             in_pkt_q;
  logic [HI_W-1:0]  pid_hi_q;
  logic             match_q;
  logic [1:0]       afc_q;
  logic             af_nz_q;
  logic             pcr_on_q;
  logic             body;

  assign body = byte_vld_i && !soft_rst_i && !pkt_start_i && in_pkt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      in_pkt_q <= 1'b0;
      pid_hi_q <= '0;
      match_q  <= 1'b0;
      afc_q    <= '0;
      af_nz_q  <= 1'b0;
      pcr_on_q <= 1'b0;
    end else if (soft_rst_i) begin
      cnt_q    <= '0;
      in_pkt_q <= 1'b0;
      pid_hi_q <= '0;
      match_q  <= 1'b0;
      afc_q    <= '0;
      af_nz_q  <= 1'b0;
      pcr_on_q <= 1'b0;
    end else if (byte_vld_i) begin
      if (pkt_start_i) begin
        in_pkt_q <= (byte_i == SYNC_BYTE);
        cnt_q    <= CNT_W'(1);
        match_q  <= 1'b0;
        pcr_on_q <= 1'b0;
      end else if (in_pkt_q) begin
        if (cnt_q == I_LAST) in_pkt_q <= 1'b0;
        else                 cnt_q    <= cnt_q + CNT_W'(1);
        if (cnt_q == I_PID_HI) pid_hi_q <= byte_i[HI_W-1:0];
        if (cnt_q == I_PID_LO) match_q  <= pid_vld_i && ({pid_hi_q, byte_i} == pid_i);
        if (cnt_q == I_HDR)    afc_q    <= byte_i[5:4];
        if (cnt_q == I_AFLEN)  af_nz_q  <= (byte_i != 8'd0);
        if (cnt_q == I_AFFLG)  pcr_on_q <= match_q && afc_q[1] && af_nz_q && byte_i[4];
      end
    end
  end

  assign hdr_evt_o  = body && (cnt_q == I_HDR) && match_q;
  assign cc_o       = byte_i[CC_W-1:0];
  assign payload_o  = byte_i[4];
  assign disc_evt_o = body && (cnt_q == I_AFFLG) && match_q && afc_q[1] && af_nz_q && byte_i[7];
  assign pcr_byte_o = body && pcr_on_q && (cnt_q >= I_PCR0) && (cnt_q <= I_PCRN);
  assign pcr_last_o = body && pcr_on_q && (cnt_q == I_PCRN);
endmodule

// File: rtl/pcr_capture.sv
module pcr_capture
  import pcr_pkg::*;
#(
  parameter int BW = BASE_W,
  parameter int EW = EXT_W,
  parameter int RW = RSVD_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          soft_rst_i,
  input  logic [7:0]    byte_i,
  input  logic          pcr_byte_i,
  input  logic          pcr_last_i,
  output logic [BW-1:0] base_o,
  output logic [EW-1:0] ext_o,
  output logic          cmp_o
);
  localparam int FLD_W = BW + RW + EW;
  localparam int SH_W  = FLD_W - 8;

  logic [SH_W-1:0]  sh_q;
  logic [FLD_W-1:0] full;

  assign full = {sh_q, byte_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      base_o <= '0;
      ext_o  <= '0;
      cmp_o  <= 1'b0;
    end else begin
      cmp_o <= pcr_last_i;
      if (soft_rst_i) begin
        sh_q <= '0;
      end else if (pcr_byte_i) begin
        sh_q <= {sh_q[SH_W-9:0], byte_i};
      end
      if (pcr_last_i) begin
        base_o <= full[FLD_W-1 -: BW];
        ext_o  <= full[EW-1:0];
      end
    end
  end
endmodule

// File: rtl/load_tracker.sv
module load_tracker
  import pcr_pkg::*;
#(
  parameter int CW = CC_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          soft_rst_i,
  input  logic          pid_wr_i,
  input  logic          pid_set_i,
  input  logic          hdr_evt_i,
  input  logic [CW-1:0] cc_i,
  input  logic          payload_i,
  input  logic          disc_evt_i,
  input  logic          pcr_last_i,
  output logic          load_o
);
  logic          cc_known_q;
  logic [CW-1:0] cc_q;
  logic          pend_q;
  logic [CW-1:0] cc_exp;
  logic          jump;

  assign cc_exp = payload_i ? cc_q + CW'(1) : cc_q;
  assign jump   = hdr_evt_i && cc_known_q && (cc_i != cc_exp);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cc_known_q <= 1'b0;
      cc_q       <= '0;
      pend_q     <= 1'b0;
      load_o     <= 1'b0;
    end else begin
      load_o <= pcr_last_i && pend_q;
      // a new cause wins over the clear from an issued load
      if (pid_set_i || jump || disc_evt_i) pend_q <= 1'b1;
      else if (pcr_last_i)                 pend_q <= 1'b0;
      if (soft_rst_i || pid_wr_i) begin
        cc_known_q <= 1'b0;
      end else if (hdr_evt_i) begin
        cc_known_q <= 1'b1;
        cc_q       <= cc_i;
      end
    end
  end
endmodule

// File: rtl/pcr_extract.sv
module pcr_extract
  import pcr_pkg::*;
#(
  parameter int PW = PID_W,
  parameter int BW = BASE_W,
  parameter int EW = EXT_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          soft_rst_i,
  input  logic [7:0]    byte_i,
  input  logic          byte_vld_i,
  input  logic          pkt_start_i,
  input  logic          pid_wr_i,
  input  logic [PW-1:0] pid_wdata_i,
  input  logic          pid_wvld_i,
  output logic [BW-1:0] pcr_base_o,
  output logic [EW-1:0] pcr_ext_o,
  output logic          cmp_evt_o,
  output logic          load_evt_o
);
  logic [PW-1:0]   pid_q;
  logic            pid_vld_q;
  logic            hdr_evt, payload, disc_evt, pcr_byte, pcr_last;
  logic [CC_W-1:0] cc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pid_q     <= '0;
      pid_vld_q <= 1'b0;
    end else if (pid_wr_i) begin
      pid_q     <= pid_wdata_i;
      pid_vld_q <= pid_wvld_i;
    end
  end

  ts_pkt_parser #(.PKT_BYTES(PKT_LEN), .PW(PW), .NPCR((BW + RSVD_W + EW) / 8)) u_parse (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .soft_rst_i (soft_rst_i),
    .byte_i     (byte_i),
    .byte_vld_i (byte_vld_i),
    .pkt_start_i(pkt_start_i),
    .pid_i      (pid_q),
    .pid_vld_i  (pid_vld_q),
    .hdr_evt_o  (hdr_evt),
    .cc_o       (cc),
    .payload_o  (payload),
    .disc_evt_o (disc_evt),
    .pcr_byte_o (pcr_byte),
    .pcr_last_o (pcr_last)
  );

  pcr_capture #(.BW(BW), .EW(EW), .RW(RSVD_W)) u_cap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .soft_rst_i (soft_rst_i),
    .byte_i     (byte_i),
    .pcr_byte_i (pcr_byte),
    .pcr_last_i (pcr_last),
    .base_o     (pcr_base_o),
    .ext_o      (pcr_ext_o),
    .cmp_o      (cmp_evt_o)
  );

  load_tracker #(.CW(CC_W)) u_load (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .soft_rst_i (soft_rst_i),
    .pid_wr_i   (pid_wr_i),
    .pid_set_i  (pid_wr_i && pid_wvld_i),
    .hdr_evt_i  (hdr_evt),
    .cc_i       (cc),
    .payload_i  (payload),
    .disc_evt_i (disc_evt),
    .pcr_last_i (pcr_last),
    .load_o     (load_evt_o)
  );
endmodule

// File: rtl/pcr_extract_chk.sv
module pcr_extract_chk #(
  parameter int BW = 33,
  parameter int EW = 9
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          soft_rst_i,
  input logic [BW-1:0] pcr_base_o,
  input logic [EW-1:0] pcr_ext_o,
  input logic          cmp_evt_o,
  input logic          load_evt_o
);
  a_r5_load_with_cmp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_evt_o |-> cmp_evt_o);
  a_r4_cmp_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_evt_o |=> !cmp_evt_o);
  a_r4_base_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmp_evt_o |-> $stable(pcr_base_o));
  a_r4_ext_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmp_evt_o |-> $stable(pcr_ext_o));
  a_r10_soft_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> !cmp_evt_o);
endmodule

bind pcr_extract pcr_extract_chk #(.BW(BW), .EW(EW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .soft_rst_i (soft_rst_i),
  .pcr_base_o (pcr_base_o),
  .pcr_ext_o  (pcr_ext_o),
  .cmp_evt_o  (cmp_evt_o),
  .load_evt_o (load_evt_o)
);

// File: tb/sim_pcr_extract.sv
module sim_pcr_extract;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst = 1'b0;
  logic [7:0]  byte_d = '0;
  logic        byte_vld = 1'b0;
  logic        pkt_start = 1'b0;
  logic        pid_wr = 1'b0;
  logic [12:0] pid_wdata = '0;
  logic        pid_wvld = 1'b0;
  logic [32:0] pcr_base;
  logic [8:0]  pcr_ext;
  logic        cmp_evt, load_evt;

  int n_tests = 0;
  int n_fail  = 0;
  int n_cmp   = 0;
  int exp_cmp_total = 0;

  typedef struct {
    logic [32:0] base;
    logic [8:0]  ext;
    logic        ld;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  always #(CLK_P/2) clk = ~clk;

  pcr_extract u0 (
    .clk_i(clk), .rst_ni(rst_n), .soft_rst_i(soft_rst),
    .byte_i(byte_d), .byte_vld_i(byte_vld), .pkt_start_i(pkt_start),
    .pid_wr_i(pid_wr), .pid_wdata_i(pid_wdata), .pid_wvld_i(pid_wvld),
    .pcr_base_o(pcr_base), .pcr_ext_o(pcr_ext),
    .cmp_evt_o(cmp_evt), .load_evt_o(load_evt)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on each compare event
  always @(negedge clk) begin
    if (rst_n) begin
      if (cmp_evt) begin
        n_cmp++;
        if (sb_q.size() == 0) begin
          chk(0, "R2", "unexpected compare event", 1, 0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          chk(pcr_base == e.base, "R3", {e.tag, " base"}, pcr_base, e.base);
          chk(pcr_ext == e.ext, "R3", {e.tag, " ext"}, pcr_ext, e.ext);
          chk(load_evt == e.ld, e.tag, "load flag", load_evt, e.ld);
        end
      end else if (load_evt) begin
        chk(0, "R5", "load without compare", 1, 0);
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      byte_vld = 1'b0; pkt_start = 1'b0;
    end
  endtask

  task automatic put_byte(input logic [7:0] b, input logic st);
    @(posedge clk); #1;
    byte_d = b; byte_vld = 1'b1; pkt_start = st;
  endtask

  task automatic wr_pid(input logic [12:0] p, input logic v);
    @(posedge clk); #1;
    byte_vld = 1'b0; pkt_start = 1'b0;
    pid_wr = 1'b1; pid_wdata = p; pid_wvld = v;
    @(posedge clk); #1;
    pid_wr = 1'b0;
  endtask

  task automatic send_pkt(input logic [7:0] sync, input logic [12:0] pid,
                          input logic [1:0] afc, input logic [3:0] cc,
                          input logic [7:0] aflen, input logic disc,
                          input logic pflag, input logic [32:0] base,
                          input logic [8:0] ext, input logic exp_c,
                          input logic exp_ld, input string tag,
                          input int nbytes, input logic gaps);
    logic [47:0] fld;
    logic [7:0]  b;
    fld = {base, 6'h3f, ext};
    if (exp_c) begin
      exp_t e;
      e.base = base; e.ext = ext; e.ld = exp_ld; e.tag = tag;
      sb_q.push_back(e);
      exp_cmp_total++;
    end
    for (int i = 0; i < nbytes; i++) begin
      case (i)
        0: b = sync;
        1: b = {3'b010, pid[12:8]};
        2: b = pid[7:0];
        3: b = {2'b00, afc, cc};
        4: b = aflen;
        5: b = {disc, 2'b00, pflag, 4'h0};
        6, 7, 8, 9, 10, 11: b = fld[8*(11-i) +: 8];
        default: b = 8'hff;
      endcase
      put_byte(b, i == 0);
      if (gaps && i < 20) idle(1);
    end
    idle(3);
    chk(sb_q.size() == 0, tag, "pending expected events", sb_q.size(), 0);
    chk(n_cmp == exp_cmp_total, tag, "compare event count", n_cmp, exp_cmp_total);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_fail++;
    $display("FAIL watchdog expired: actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(pcr_base == '0, "R1", "base", pcr_base, 0);
    chk(pcr_ext == '0, "R1", "ext", pcr_ext, 0);
    chk(!cmp_evt && !load_evt, "R1", "events", {cmp_evt, load_evt}, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    idle(2);

    // R1: no PID enabled, PID 0 must not match
    send_pkt(8'h47, 13'h000, 2'b11, 4'd0, 8'd7, 0, 1, 33'h0_0000_0001, 9'h001, 0, 0, "R1", 188, 0);

    wr_pid(13'h123, 1);
    send_pkt(8'h47, 13'h123, 2'b11, 4'd0, 8'd7, 0, 1, 33'h1_2345_6789, 9'h12b, 1, 1, "R5", 188, 0);
    send_pkt(8'h47, 13'h123, 2'b11, 4'd1, 8'd7, 0, 1, 33'h1_0000_0001, 9'h100, 1, 0, "R8", 188, 0);
    send_pkt(8'h47, 13'h124, 2'b11, 4'd2, 8'd7, 0, 1, 33'h0_5555_5555, 9'h055, 0, 0, "R2", 188, 0);
    // payload only: byte 5 flags look like a PCR but no adaptation field
    send_pkt(8'h47, 13'h123, 2'b01, 4'd2, 8'd7, 0, 1, 33'h0_1111_1111, 9'h011, 0, 0, "R3", 188, 0);
    send_pkt(8'h47, 13'h123, 2'b11, 4'd3, 8'd0, 0, 1, 33'h0_2222_2222, 9'h022, 0, 0, "R3", 188, 0);
    send_pkt(8'h47, 13'h123, 2'b11, 4'd4, 8'd7, 0, 0, 33'h0_3333_3333, 9'h033, 0, 0, "R3", 188, 0);
    @(negedge clk);
    chk(pcr_base == 33'h1_0000_0001, "R4", "base held", pcr_base, 33'h1_0000_0001);
    chk(pcr_ext == 9'h100, "R4", "ext held", pcr_ext, 9'h100);

    send_pkt(8'h47, 13'h123, 2'b11, 4'd5, 8'd7, 1, 1, 33'h0_0abc_def0, 9'h0ff, 1, 1, "R6", 188, 0);
    send_pkt(8'h47, 13'h123, 2'b11, 4'd9, 8'd7, 0, 1, 33'h1_ffff_ffff, 9'h1ff, 1, 1, "R7", 188, 0);
    // adaptation only: counter repeats without a jump
    send_pkt(8'h47, 13'h123, 2'b10, 4'd9, 8'd7, 0, 1, 33'h0_0000_0000, 9'h000, 1, 0, "R7", 188, 0);
    send_pkt(8'h47, 13'h123, 2'b11, 4'd10, 8'd7, 0, 1, 33'h0_7654_3210, 9'h0a5, 1, 0, "R11", 188, 1);
    send_pkt(8'h46, 13'h123, 2'b11, 4'd11, 8'd7, 0, 1, 33'h0_4444_4444, 9'h044, 0, 0, "R2", 188, 0);

    // R10: abandon a packet mid-way, then feed its tail
    send_pkt(8'h47, 13'h123, 2'b11, 4'd11, 8'd7, 0, 1, 33'h0_6666_6666, 9'h066, 0, 0, "R10", 8, 0);
    @(posedge clk); #1;
    byte_vld = 1'b0; soft_rst = 1'b1;
    @(posedge clk); #1;
    soft_rst = 1'b0;
    for (int i = 8; i < 188; i++) put_byte(8'h10, 1'b0);
    idle(3);
    chk(n_cmp == exp_cmp_total, "R10", "tail after soft reset", n_cmp, exp_cmp_total);
    send_pkt(8'h47, 13'h123, 2'b11, 4'd7, 8'd7, 0, 1, 33'h0_1357_9bdf, 9'h135, 1, 0, "R10", 188, 0);

    // R11: restart in mid-packet
    send_pkt(8'h47, 13'h123, 2'b11, 4'd8, 8'd7, 0, 1, 33'h0_0f0f_0f0f, 9'h00f, 0, 0, "R11", 10, 0);
    send_pkt(8'h47, 13'h123, 2'b11, 4'd9, 8'd7, 0, 1, 33'h1_8000_0000, 9'h080, 1, 0, "R11", 188, 0);

    wr_pid(13'h123, 1);
    send_pkt(8'h47, 13'h123, 2'b11, 4'd10, 8'd7, 0, 1, 33'h0_2468_ace0, 9'h024, 1, 1, "R5", 188, 0);
    send_pkt(8'h47, 13'h123, 2'b11, 4'd11, 8'd7, 0, 1, 33'h0_0246_8ace, 9'h102, 1, 0, "R8", 188, 0);

    wr_pid(13'h123, 0);
    send_pkt(8'h47, 13'h123, 2'b11, 4'd12, 8'd7, 0, 1, 33'h0_9999_9999, 9'h099, 0, 0, "R9", 188, 0);

    wr_pid(13'h1fff, 1);
    send_pkt(8'h47, 13'h1fff, 2'b11, 4'd0, 8'd7, 0, 1, 33'h1_abcd_ef01, 9'h1a5, 1, 1, "R2", 188, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule